// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip. It takes the four serial test pins (test clock, mode select, serial data in and an active-low asynchronous test reset) and drives serial data out together with an output enable for the pad. Inside are the sixteen-state port controller, a five-bit instruction register, a one-bit bypass register and a 32-bit identification register.

The active instruction is decoded into select lines for a boundary register that lives outside this block. The capture, shift and update strobes for the data-register column are exported so that the boundary cells can be chained in. While the boundary register is selected, its serial output is fed back through `bsr_tdo`. Any opcode that is not one of the four public ones, including reserved vendor opcodes, selects the bypass register.

Top module: `scan_tap_ctrl`

## Requirements
- R1: Driving `trst_n` low asynchronously puts the controller in Test-Logic-Reset, forces `tdo_oe` low, and makes IDCODE (00010) the active instruction, with no clock edge needed.
- R2: Five rising clock edges with `tms` high reach Test-Logic-Reset from any state. On that entry the active instruction becomes IDCODE.
- R3: In Capture-IR the instruction shift register loads 00001. It shifts out least significant bit first, and `tdi` enters at the most significant bit.
- R4: The active instruction changes only on the falling clock edge while in Update-IR. Shifting, Exit1-IR, Pause-IR and Exit2-IR leave the select outputs unchanged.
- R5: Opcode 00000 raises `sel_extest`, opcode 10000 raises `sel_sample`, and either one raises `sel_bsr`. At most one of `sel_extest` and `sel_sample` is high.
- R6: Opcode 00010 selects the 32-bit identification register. It captures 0x227A50CB: version 0010 in bits 31..28, part 0010011110100101 in bits 27..12, maker 00001100101 in bits 11..1 and a constant 1 in bit 0. It is shifted out LSB first.
- R7: Opcode 11111, and every opcode other than 00000, 10000 and 00010, selects the one-bit bypass register. That register captures 0 and delays `tdi` by one shift.
- R8: `tdo` and `tdo_oe` change only on the falling clock edge. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.
- R9: `capture_dr`, `shift_dr` and `update_dr` are high exactly in Capture-DR, Shift-DR and Update-DR respectively. After Capture-DR the next state is never Capture-DR or Update-DR, and Update-DR is never followed by Capture-DR or Shift-DR.
- R10: While the boundary register is selected, `tdo` in Shift-DR carries `bsr_tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| bsr_tdo | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Pad enable for `tdo`; the pad is high-Z when low |
| sel_extest | output | 1 | External-test instruction active |
| sel_sample | output | 1 | Sample/preload instruction active |
| sel_bsr | output | 1 | Boundary register is the selected data register |
| capture_dr | output | 1 | Controller is in Capture-DR |
| shift_dr | output | 1 | Controller is in Shift-DR |
| update_dr | output | 1 | Controller is in Update-DR |

## Verification
A wrong controller state shows up within one falling edge, because `tdo_oe` and the three strobes follow the state directly. A faulty instruction register shows up on the select lines at the falling edge of Update-IR. It also shows up in the first bit shifted out of Shift-DR, since the bypass register captures 0, the identification register captures 1 and the boundary path copies `bsr_tdo`. A wrong capture pattern or a wrong shift direction is caught on the first five bits of every instruction load. Any bit error in the identification register shows in the 32-bit word read after each reset.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET  = 4'd0,
    ST_IDLE   = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_t;

  typedef enum logic [1:0] {
    DRS_BYPASS   = 2'd0,
    DRS_IDENT    = 2'd1,
    DRS_BOUNDARY = 2'd2
  } dr_sel_t;

  // Port controller transition on one rising edge of the test clock.
  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    tap_state_t n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
#(
  parameter int                IR_W       = 5,
  parameter logic [IR_W-1:0]   IR_CAPTURE = 5'b00001,
  parameter logic [IR_W-1:0]   OP_BYPASS  = 5'b11111,
  parameter logic [IR_W-1:0]   OP_EXTEST  = 5'b00000,
  parameter logic [IR_W-1:0]   OP_SAMPLE  = 5'b10000,
  parameter logic [IR_W-1:0]   OP_IDCODE  = 5'b00010
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_t state,
  input  logic       tdi,
  output logic       ir_lsb,
  output dr_sel_t    dr_sel,
  output logic       sel_extest,
  output logic       sel_sample
);

  logic [IR_W-1:0] shreg_q;
  logic [IR_W-1:0] instr_q;

  // Capture and shift on the rising edge.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      shreg_q <= IR_CAPTURE;
    end else if (state == ST_CAP_IR) begin
      shreg_q <= IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      shreg_q <= {tdi, shreg_q[IR_W-1:1]};
    end
  end

  // The active instruction moves only on the falling edge.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      instr_q <= OP_IDCODE;
    end else if (state == ST_RESET) begin
      instr_q <= OP_IDCODE;
    end else if (state == ST_UPD_IR) begin
      instr_q <= shreg_q;
    end
  end

  assign ir_lsb = shreg_q[0];

  always_comb begin
    sel_extest = 1'b0;
    sel_sample = 1'b0;
    dr_sel     = DRS_BYPASS;
    if (instr_q == OP_BYPASS) begin
      dr_sel = DRS_BYPASS;
    end else if (instr_q == OP_EXTEST) begin
      sel_extest = 1'b1;
      dr_sel     = DRS_BOUNDARY;
    end else if (instr_q == OP_SAMPLE) begin
      sel_sample = 1'b1;
      dr_sel     = DRS_BOUNDARY;
    end else if (instr_q == OP_IDCODE) begin
      dr_sel = DRS_IDENT;
    end
  end

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_t state,
  input  logic       tdi,
  input  dr_sel_t    dr_sel,
  input  logic       bsr_tdo,
  output logic       dr_tdo
);

  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
    end else if (dr_sel == DRS_BYPASS) begin
      if (state == ST_CAP_DR)     byp_q <= 1'b0;
      else if (state == ST_SH_DR) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_q <= ID_VALUE;
    end else if (dr_sel == DRS_IDENT) begin
      if (state == ST_CAP_DR)     id_q <= ID_VALUE;
      else if (state == ST_SH_DR) id_q <= {tdi, id_q[ID_W-1:1]};
    end
  end

  always_comb begin
    case (dr_sel)
      DRS_IDENT:    dr_tdo = id_q[0];
      DRS_BOUNDARY: dr_tdo = bsr_tdo;
      default:      dr_tdo = byp_q;
    endcase
  end

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
#(
  parameter int              IR_W       = 5,
  parameter logic [IR_W-1:0] IR_CAPTURE = 5'b00001,
  parameter logic [IR_W-1:0] OP_BYPASS  = 5'b11111,
  parameter logic [IR_W-1:0] OP_EXTEST  = 5'b00000,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 5'b10000,
  parameter logic [IR_W-1:0] OP_IDCODE  = 5'b00010,
  parameter logic [3:0]      ID_VERSION = 4'b0010,
  parameter logic [15:0]     ID_PART    = 16'b0010011110100101,
  parameter logic [10:0]     ID_MAKER   = 11'b00001100101
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_tdo,
  output logic tdo,
  output logic tdo_oe,
  output logic sel_extest,
  output logic sel_sample,
  output logic sel_bsr,
  output logic capture_dr,
  output logic shift_dr,
  output logic update_dr
);

  localparam int              ID_W     = 4 + 16 + 11 + 1;
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

  tap_state_t state_q;
  dr_sel_t    dr_sel;
  logic       ir_lsb;
  logic       dr_tdo;

  scan_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state_q)
  );

  scan_tap_ir #(
    .IR_W       (IR_W),
    .IR_CAPTURE (IR_CAPTURE),
    .OP_BYPASS  (OP_BYPASS),
    .OP_EXTEST  (OP_EXTEST),
    .OP_SAMPLE  (OP_SAMPLE),
    .OP_IDCODE  (OP_IDCODE)
  ) u_ir (
    .tck        (tck),
    .trst_n     (trst_n),
    .state      (state_q),
    .tdi        (tdi),
    .ir_lsb     (ir_lsb),
    .dr_sel     (dr_sel),
    .sel_extest (sel_extest),
    .sel_sample (sel_sample)
  );

  scan_tap_dr #(
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck     (tck),
    .trst_n  (trst_n),
    .state   (state_q),
    .tdi     (tdi),
    .dr_sel  (dr_sel),
    .bsr_tdo (bsr_tdo),
    .dr_tdo  (dr_tdo)
  );

  assign sel_bsr    = (dr_sel == DRS_BOUNDARY);
  assign capture_dr = (state_q == ST_CAP_DR);
  assign shift_dr   = (state_q == ST_SH_DR);
  assign update_dr  = (state_q == ST_UPD_DR);

  // Serial output retimed to the falling edge.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else if (state_q == ST_SH_IR) begin
      tdo    <= ir_lsb;
      tdo_oe <= 1'b1;
    end else if (state_q == ST_SH_DR) begin
      tdo    <= dr_tdo;
      tdo_oe <= 1'b1;
    end else begin
      tdo_oe <= 1'b0;
    end
  end

endmodule

// File: rtl/scan_tap_checker.sv
module scan_tap_checker
  import scan_tap_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input tap_state_t st,
  input logic       tdo_oe,
  input logic       sel_extest,
  input logic       sel_sample,
  input logic       capture_dr,
  input logic       shift_dr,
  input logic       update_dr
);

  AST_OE_IN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (shift_dr || st == ST_SH_IR)); // R8

  AST_SHIFT_DRIVES_OE: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr || st == ST_SH_IR) |-> tdo_oe); // R8

  AST_SELECTS_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
    !(sel_extest && sel_sample)); // R5

  AST_INSTR_HELD: assert property (@(posedge tck) disable iff (!trst_n)
    !(st == ST_UPD_IR || st == ST_RESET) |-> $stable({sel_extest, sel_sample})); // R4

  AST_RESET_STATE_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_RESET) |-> (!sel_extest && !sel_sample)); // R2

  AST_CAPTURE_FOLLOWUP: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr |=> (!capture_dr && !update_dr)); // R9

  AST_UPDATE_FOLLOWUP: assert property (@(posedge tck) disable iff (!trst_n)
    update_dr |=> (!capture_dr && !shift_dr)); // R9

endmodule

bind scan_tap_ctrl scan_tap_checker u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .st         (state_q),
  .tdo_oe     (tdo_oe),
  .sel_extest (sel_extest),
  .sel_sample (sel_sample),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr)
);

// File: tb/scan_tap_ctrl_test.sv
module scan_tap_ctrl_test;

  localparam int          TCK_PERIOD = 20;
  localparam logic [31:0] ID_EXP = {4'b0010, 16'b0010011110100101, 11'b00001100101, 1'b1};
  localparam logic [32:0] DIN    = 33'h1_5A5A_C3C3;
  // opcode, expected path: 0 bypass, 1 ident, 2 extest, 3 sample
  localparam logic [6:0] VEC [0:9] = '{
    {5'b11111, 2'd0}, {5'b00000, 2'd2}, {5'b10000, 2'd3}, {5'b00010, 2'd1},
    {5'b01010, 2'd0}, {5'b00100, 2'd0}, {5'b10110, 2'd0}, {5'b00110, 2'd0},
    {5'b00001, 2'd0}, {5'b11110, 2'd0}
  };

  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b1, bsr_tdo = 1'b0;
  logic tdo, tdo_oe, sel_extest, sel_sample, sel_bsr, capture_dr, shift_dr, update_dr;
  int errors = 0;
  int checks = 0;

  always #(TCK_PERIOD/2) tck = ~tck;

  scan_tap_ctrl uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_tdo(bsr_tdo),
    .tdo(tdo), .tdo_oe(tdo_oe), .sel_extest(sel_extest), .sel_sample(sel_sample),
    .sel_bsr(sel_bsr), .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [4:0] op, output logic [4:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = tdo;
    for (int i = 0; i < 5; i++) begin
      step(i == 4, op[i]);
      if (i < 4) cap[i+1] = tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [32:0] din, output logic [32:0] dout);
    step(1, 0); step(0, 0); step(0, 0);
    dout[0] = tdo;
    for (int i = 0; i < 33; i++) begin
      step(i == 32, din[i]);
      if (i < 32) dout[i+1] = tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [4:0]  cap;
    logic [32:0] got, exp;
    logic [1:0]  kind;

    // R1: asynchronous reset state
    #2 trst_n = 1'b0;
    #3;
    chk(!tdo_oe && !sel_extest && !sel_sample && !sel_bsr && !capture_dr && !shift_dr && !update_dr,
        "R1 reset outputs", {tdo_oe, sel_extest, sel_sample, sel_bsr}, 0);
    @(negedge tck); #1 trst_n = 1'b1;
    step(0, 0);
    chk(!tdo_oe, "R8 idle oe", tdo_oe, 0);
    scan_dr(DIN, got);
    chk(got == {DIN[0], ID_EXP}, "R1 R6 id after reset", got, {DIN[0], ID_EXP});

    // Table walk: opcode decode and data path
    for (int v = 0; v < 10; v++) begin
      kind = VEC[v][1:0];
      bsr_tdo = 1'b1;
      load_ir(VEC[v][6:2], cap);
      chk(cap == 5'b00001, "R3 capture pattern", cap, 5'b00001);
      chk(sel_extest == (kind == 2'd2) && sel_sample == (kind == 2'd3) && sel_bsr == (kind >= 2'd2),
          "R5 decode", {sel_extest, sel_sample, sel_bsr}, {kind == 2'd2, kind == 2'd3, kind >= 2'd2});
      scan_dr(DIN, got);
      case (kind)
        2'd0:    exp = {DIN[31:0], 1'b0};
        2'd1:    exp = {DIN[0], ID_EXP};
        default: exp = '1;
      endcase
      chk(got == exp, (kind == 2'd0) ? "R7 bypass" : (kind == 2'd1) ? "R6 ident" : "R10 boundary",
          got, exp);
    end
    bsr_tdo = 1'b0;

    // R4: instruction changes only in Update-IR
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(i == 4, 1'b0);
    chk(!sel_extest, "R4 held in exit1", sel_extest, 0);
    step(0, 0);
    chk(!sel_extest, "R4 held in pause", sel_extest, 0);
    step(1, 0);
    chk(!sel_extest, "R4 held in exit2", sel_extest, 0);
    step(1, 0);
    chk(sel_extest, "R4 update", sel_extest, 1);
    step(0, 0);

    // R8 / R9: falling-edge output and strobes
    load_ir(5'b00010, cap);
    step(1, 0); step(0, 0);
    chk(capture_dr && !tdo_oe, "R9 capture strobe", {capture_dr, tdo_oe}, 2'b10);
    step(0, 0);
    chk(shift_dr && tdo_oe && tdo == ID_EXP[0], "R8 R9 shift entry", {shift_dr, tdo_oe, tdo}, 3'b111);
    for (int k = 1; k < 3; k++) begin
      tms = 1'b0; tdi = 1'b0;
      @(posedge tck); #1;
      chk(tdo == ID_EXP[k-1], "R8 held after rise", tdo, ID_EXP[k-1]);
      @(negedge tck); #1;
      chk(tdo == ID_EXP[k], "R8 change on fall", tdo, ID_EXP[k]);
    end
    step(1, 0);
    chk(!tdo_oe, "R8 exit disables", tdo_oe, 0);
    step(1, 0);
    chk(update_dr && !shift_dr, "R9 update strobe", {update_dr, shift_dr}, 2'b10);
    step(0, 0);

    // R2: five TMS-high edges reach reset and restore IDCODE
    load_ir(5'b00000, cap);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(1, 0);
    chk(sel_extest, "R2 not yet reset", sel_extest, 1);
    step(1, 0);
    chk(!sel_extest && !sel_bsr, "R2 reset after five", {sel_extest, sel_bsr}, 0);
    step(0, 0);
    scan_dr(DIN, got);
    chk(got == {DIN[0], ID_EXP}, "R2 idcode restored", got, {DIN[0], ID_EXP});

    // R1: asynchronous reset in the middle of Shift-DR
    load_ir(5'b00000, cap);
    step(1, 0); step(0, 0); step(0, 0);
    trst_n = 1'b0;
    #2;
    chk(!tdo_oe && !sel_extest && !shift_dr, "R1 async mid shift", {tdo_oe, sel_extest, shift_dr}, 0);
    trst_n = 1'b1;
    step(0, 0);
    scan_dr(DIN, got);
    chk(got == {DIN[0], ID_EXP}, "R1 idcode after trst", got, {DIN[0], ID_EXP});

    finish_run();
  end

endmodule